// File: doc/BRIEF.md
# QSPI Memory-Mapped Data-Phase Endian Adapter

This block handles only the data phase of a quad SPI link. On the write side, each bus store (byte, half-word or word) becomes a single FIFO entry. The serializer then shifts that entry out most significant bit first over one, two or four data lanes, and consecutive entries follow with no gap. On the read side, the bytes that arrive from the peripheral in ascending address order are collected, and the bus read value is built from them.

In memory-mapped operation, the byte order of a read depends on the access size and on one of three static ordering modes. A dynamic mode can be enabled instead. It makes both reads and writes behave like little-endian RAM, and when it is on it overrides the static setting. Outside memory-mapped operation, both settings are ignored and the plain most-significant-first order is used. The block rejects and flags three kinds of access: misaligned ones, ones with an illegal size, and memory-mapped ones while single-lane operation is selected.

Top module: `qed_endian_datapath`

## Requirements
- R1: `cfg_lanes` selects the serial width: 0 gives one lane on `tx_dat[0]`, 1 gives two lanes on `tx_dat[1:0]`, and 2 or 3 gives four lanes on `tx_dat[3:0]`. Within each step the higher-numbered lane carries the more significant bit. Lanes that are not in use stay at 0.
- R2: Each accepted write makes one entry of 8, 16 or 32 bits. The entry is sent most significant bit first, and `tx_valid` is high for exactly bits/lanes cycles per entry. `tx_valid` rises on the second clock edge after the write is accepted, and queued entries follow back to back.
- R3: Write data is right-justified in `wr_data`, and `wr_size` is 0 for byte, 1 for half-word and 2 for word. Unless the dynamic rule is active, the entry goes out as its numeric value. A half-word 0x0201 appears on the wire as 02 01, and a word 0x04030201 appears as 04 03 02 01.
- R4: The dynamic rule is active when `cfg_mmap`=1 and `cfg_dyn`=1. Under it, writes go out lowest-address byte first: a word 0x04030201 appears as 01 02 03 04, and a half-word 0x0201 appears as 01 02.
- R5: A byte read returns the received byte in `rd_data[7:0]` with zeros above it, whatever the mode.
- R6: This rule applies when `cfg_mmap`=0, or when static mode 0 or 3 is selected without the dynamic rule. Take received bytes b0,b1,b2,b3 in arrival order. A half-word read returns {b0,b1} and a word read returns {b0,b1,b2,b3}. For stored bytes 01 02 03 04, a half-word read at offset 2 returns 0x0304.
- R7: Static mode 1 returns {b1,b0} for a half-word and {b1,b0,b3,b2} for a word (0x02010403).
- R8: Static mode 2 returns {b1,b0} for a half-word and {b3,b2,b1,b0} for a word (0x04030201).
- R9: The dynamic rule returns little-endian values ({b3,b2,b1,b0}), whatever `cfg_static` holds. With `cfg_mmap`=0, `cfg_dyn` has no effect.
- R10: The following are rejected: a half-word at an odd offset, a word at a nonzero offset, and size code 3. The matching error output pulses one cycle after the request. A rejected write sends nothing, and a rejected read never asserts `rd_done`.
- R11: When `cfg_mmap`=1 and `cfg_lanes`=0, every write or read is rejected in the same way as in R10.
- R12: After reset, `wr_ready`=1, and `tx_valid`, `rd_done`, `rd_busy`, `wr_err` and `rd_err` are all 0.
- R13: `wr_ready` is low while the FIFO holds FIFO_DEPTH entries. A write offered while `wr_ready` is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mmap | input | 1 | Memory-mapped operation enable |
| cfg_dyn | input | 1 | Dynamic (little-endian RAM) rule enable |
| cfg_static | input | 2 | Static read ordering mode |
| cfg_lanes | input | 2 | Serial width: 0 single, 1 dual, 2/3 quad |
| wr_valid | input | 1 | Write request |
| wr_size | input | 2 | Write size: 0 byte, 1 half-word, 2 word |
| wr_off | input | 2 | Byte offset of the write within its word |
| wr_data | input | 32 | Right-justified write data |
| wr_ready | output | 1 | FIFO can accept a write |
| wr_err | output | 1 | Write rejected (one-cycle pulse) |
| tx_valid | output | 1 | Serial data step valid |
| tx_dat | output | 4 | Serial data lanes |
| rd_start | input | 1 | Begin collecting a read |
| rd_size | input | 2 | Read size: 0 byte, 1 half-word, 2 word |
| rd_off | input | 2 | Byte offset of the read within its word |
| rx_valid | input | 1 | Received peripheral byte valid |
| rx_byte | input | 8 | Received peripheral byte |
| rd_busy | output | 1 | Read collection in progress |
| rd_done | output | 1 | Read value ready (one-cycle pulse) |
| rd_data | output | 32 | Assembled read value, held until the next start |
| rd_err | output | 1 | Read rejected (one-cycle pulse) |

## Verification
The write serializer and the read assembler are independent, so a read can collect bytes while an earlier write entry is still shifting out. The bench provokes this by issuing a word write under the dynamic rule and starting a word read in the next cycle. It then judges the wire bytes and the returned value separately against their little-endian expectations. A second overlap occurs inside the serializer, when an entry ends in the same cycle the next one loads. This is provoked by queuing words until the FIFO is full. It is judged by the count of valid cycles and the byte sequence, which together show there was no gap and no lost entry.

// File: rtl/qed_pkg.sv
package qed_pkg;
   localparam int QED_BUS_W  = 32;
   localparam int QED_LANES  = 4;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   localparam logic [1:0] LN_SINGLE = 2'd0;
   localparam logic [1:0] LN_DUAL   = 2'd1;

   typedef enum logic [1:0] {
      ORD_BE    = 2'd0,
      ORD_SWP16 = 2'd1,
      ORD_LE    = 2'd2
   } qed_order_e;

   typedef struct packed {
      logic [1:0]           size;
      logic [QED_BUS_W-1:0] data;
   } qed_entry_t;

   function automatic logic size_bad(input logic [1:0] size, input logic [1:0] off);
      case (size)
         SZ_BYTE: size_bad = 1'b0;
         SZ_HALF: size_bad = off[0];
         SZ_WORD: size_bad = (off != 2'd0);
         default: size_bad = 1'b1;
      endcase
   endfunction

   function automatic logic [QED_BUS_W-1:0] swap_in_width(input logic [QED_BUS_W-1:0] d,
                                                          input logic [1:0] size);
      case (size)
         SZ_HALF: swap_in_width = {16'h0, d[7:0], d[15:8]};
         SZ_WORD: swap_in_width = {d[7:0], d[15:8], d[23:16], d[31:24]};
         default: swap_in_width = {24'h0, d[7:0]};
      endcase
   endfunction

   function automatic logic [QED_BUS_W-1:0] order_bytes(input logic [3:0][7:0] b,
                                                        input logic [1:0] size,
                                                        input qed_order_e ord);
      logic [QED_BUS_W-1:0] r;
      r = '0;
      case (size)
         SZ_BYTE: r = {24'h0, b[0]};
         SZ_HALF: r = (ord == ORD_BE) ? {16'h0, b[0], b[1]} : {16'h0, b[1], b[0]};
         default: begin
            case (ord)
               ORD_SWP16: r = {b[1], b[0], b[3], b[2]};
               ORD_LE:    r = {b[3], b[2], b[1], b[0]};
               default:   r = {b[0], b[1], b[2], b[3]};
            endcase
         end
      endcase
      return r;
   endfunction
endpackage

// File: rtl/qed_wr_packer.sv
module qed_wr_packer
   import qed_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mmap,
   input  logic              cfg_dyn,
   input  logic [1:0]        cfg_lanes,
   input  logic              wr_valid,
   input  logic [1:0]        wr_size,
   input  logic [1:0]        wr_off,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              fifo_full,
   output logic              push,
   output qed_entry_t        push_entry,
   output logic              wr_err
);
   logic reject;
   logic dyn_act;

   always_comb begin
      dyn_act = cfg_mmap & cfg_dyn;
      reject  = size_bad(wr_size, wr_off) | (cfg_mmap & (cfg_lanes == LN_SINGLE));
      push    = wr_valid & ~fifo_full & ~reject;
      push_entry.size = wr_size;
      push_entry.data = dyn_act ? swap_in_width(wr_data, wr_size)
                                : swap_in_width(swap_in_width(wr_data, wr_size), wr_size);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_err <= 1'b0;
      else        wr_err <= wr_valid & reject;
   end
endmodule

// File: rtl/qed_entry_fifo.sv
module qed_entry_fifo
   import qed_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  qed_entry_t    push_entry,
   input  logic          pop,
   output qed_entry_t    head,
   output logic          empty,
   output logic          full,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH+1);

   qed_entry_t        mem [DEPTH];
   logic [PTR_W-1:0]  wp, rp;
   logic              do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = mem[rp];

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= nxt(wp);
         if (do_pop)  rp <= nxt(rp);
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_entry;
   end
endmodule

// File: rtl/qed_lane_serializer.sv
module qed_lane_serializer
   import qed_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int LANES_MAX = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           cfg_lanes,
   input  logic                 fifo_empty,
   input  qed_entry_t           head,
   output logic                 pop,
   output logic                 tx_valid,
   output logic [LANES_MAX-1:0] tx_dat
);
   localparam int CNT_W = $clog2(DATA_W+1);

   logic [DATA_W-1:0] sh;
   logic [CNT_W-1:0]  rem;
   logic [2:0]        lane_n;
   logic [1:0]        lane_log;
   logic [CNT_W-1:0]  bits;
   logic [DATA_W-1:0] load_val;

   always_comb begin
      case (cfg_lanes)
         LN_SINGLE: begin lane_n = 3'd1; lane_log = 2'd0; end
         LN_DUAL:   begin lane_n = 3'd2; lane_log = 2'd1; end
         default:   begin lane_n = 3'd4; lane_log = 2'd2; end
      endcase
      case (head.size)
         SZ_BYTE: bits = CNT_W'(8);
         SZ_HALF: bits = CNT_W'(16);
         default: bits = CNT_W'(DATA_W);
      endcase
      load_val = head.data << (CNT_W'(DATA_W) - bits);
      pop      = ~fifo_empty & (rem <= CNT_W'(1));
      tx_valid = (rem != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         rem <= '0;
      end else if (pop) begin
         sh  <= load_val;
         rem <= bits >> lane_log;
      end else if (rem != '0) begin
         sh  <= sh << lane_n;
         rem <= rem - 1'b1;
      end
   end

   for (genvar g = 0; g < LANES_MAX; g++) begin : g_lane
      always_comb begin
         tx_dat[g] = 1'b0;
         if (tx_valid && (g < int'(lane_n)))
            tx_dat[g] = sh[DATA_W - int'(lane_n) + g];
      end
   end
endmodule

// File: rtl/qed_rd_assembler.sv
module qed_rd_assembler
   import qed_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mmap,
   input  logic              cfg_dyn,
   input  logic [1:0]        cfg_static,
   input  logic [1:0]        cfg_lanes,
   input  logic              rd_start,
   input  logic [1:0]        rd_size,
   input  logic [1:0]        rd_off,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   output logic              rd_busy,
   output logic              rd_done,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_err,
   output logic [1:0]        size_lat
);
   logic [3:0][7:0] bytes_q;
   logic [1:0]      cnt;
   logic [1:0]      last_idx;
   qed_order_e      ord_q, ord_sel;
   logic            reject;

   always_comb begin
      if (!cfg_mmap)        ord_sel = ORD_BE;
      else if (cfg_dyn)     ord_sel = ORD_LE;
      else begin
         case (cfg_static)
            2'd1:    ord_sel = ORD_SWP16;
            2'd2:    ord_sel = ORD_LE;
            default: ord_sel = ORD_BE;
         endcase
      end
      reject  = size_bad(rd_size, rd_off) | (cfg_mmap & (cfg_lanes == LN_SINGLE));
      case (size_lat)
         SZ_BYTE: last_idx = 2'd0;
         SZ_HALF: last_idx = 2'd1;
         default: last_idx = 2'd3;
      endcase
      rd_data = order_bytes(bytes_q, size_lat, ord_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bytes_q  <= '0;
         cnt      <= '0;
         rd_busy  <= 1'b0;
         rd_done  <= 1'b0;
         rd_err   <= 1'b0;
         size_lat <= SZ_BYTE;
         ord_q    <= ORD_BE;
      end else begin
         rd_done <= 1'b0;
         rd_err  <= 1'b0;
         if (!rd_busy && rd_start) begin
            if (reject) begin
               rd_err <= 1'b1;
            end else begin
               rd_busy  <= 1'b1;
               size_lat <= rd_size;
               ord_q    <= ord_sel;
               bytes_q  <= '0;
               cnt      <= '0;
            end
         end else if (rd_busy && rx_valid) begin
            bytes_q[cnt] <= rx_byte;
            cnt          <= cnt + 1'b1;
            if (cnt == last_idx) begin
               rd_busy <= 1'b0;
               rd_done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/qed_endian_datapath.sv
module qed_endian_datapath
   import qed_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int LANES_MAX  = 4,
   parameter int FIFO_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mmap,
   input  logic              cfg_dyn,
   input  logic [1:0]        cfg_static,
   input  logic [1:0]        cfg_lanes,
   input  logic              wr_valid,
   input  logic [1:0]        wr_size,
   input  logic [1:0]        wr_off,
   input  logic [31:0]       wr_data,
   output logic              wr_ready,
   output logic              wr_err,
   output logic              tx_valid,
   output logic [3:0]        tx_dat,
   input  logic              rd_start,
   input  logic [1:0]        rd_size,
   input  logic [1:0]        rd_off,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   output logic              rd_busy,
   output logic              rd_done,
   output logic [31:0]       rd_data,
   output logic              rd_err
);
   localparam int CNT_W = $clog2(FIFO_DEPTH+1);

   if (DATA_W != QED_BUS_W) begin : g_bad_width
      $error("qed_endian_datapath: DATA_W must equal the 32-bit bus width");
   end
   if (LANES_MAX != QED_LANES) begin : g_bad_lanes
      $error("qed_endian_datapath: LANES_MAX must be 4");
   end
   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("qed_endian_datapath: FIFO_DEPTH must be at least 2");
   end

   logic             push, pop, fifo_empty, fifo_full;
   qed_entry_t       push_entry, head;
   logic [CNT_W-1:0] fifo_count;
   logic [1:0]       rd_size_lat;

   assign wr_ready = ~fifo_full;

   qed_wr_packer #(.DATA_W(DATA_W)) packer_i (
      .clk(clk), .rst_n(rst_n), .cfg_mmap(cfg_mmap), .cfg_dyn(cfg_dyn),
      .cfg_lanes(cfg_lanes), .wr_valid(wr_valid), .wr_size(wr_size),
      .wr_off(wr_off), .wr_data(wr_data), .fifo_full(fifo_full),
      .push(push), .push_entry(push_entry), .wr_err(wr_err)
   );

   qed_entry_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
      .clk(clk), .rst_n(rst_n), .push(push), .push_entry(push_entry),
      .pop(pop), .head(head), .empty(fifo_empty), .full(fifo_full),
      .count(fifo_count)
   );

   qed_lane_serializer #(.DATA_W(DATA_W), .LANES_MAX(LANES_MAX)) ser_i (
      .clk(clk), .rst_n(rst_n), .cfg_lanes(cfg_lanes), .fifo_empty(fifo_empty),
      .head(head), .pop(pop), .tx_valid(tx_valid), .tx_dat(tx_dat)
   );

   qed_rd_assembler #(.DATA_W(DATA_W)) asm_i (
      .clk(clk), .rst_n(rst_n), .cfg_mmap(cfg_mmap), .cfg_dyn(cfg_dyn),
      .cfg_static(cfg_static), .cfg_lanes(cfg_lanes), .rd_start(rd_start),
      .rd_size(rd_size), .rd_off(rd_off), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rd_busy(rd_busy), .rd_done(rd_done), .rd_data(rd_data), .rd_err(rd_err),
      .size_lat(rd_size_lat)
   );
endmodule

// File: rtl/qed_endian_datapath_chk.sv
module qed_endian_datapath_chk #(
   parameter int FIFO_DEPTH = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_mmap,
   input logic [1:0]  cfg_lanes,
   input logic        wr_valid,
   input logic [1:0]  wr_size,
   input logic [1:0]  wr_off,
   input logic        wr_err,
   input logic        tx_valid,
   input logic [3:0]  tx_dat,
   input logic        rd_done,
   input logic        rd_err,
   input logic [31:0] rd_data,
   input logic [1:0]  rd_size_lat,
   input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count
);
   // R13
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

   // R10
   misalign_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_size == 2'd1 && wr_off[0]) |=> wr_err);

   // R11
   mmap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && cfg_mmap && cfg_lanes == 2'd0) |=> wr_err);

   // R1
   single_lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && cfg_lanes == 2'd0) |-> tx_dat[3:1] == 3'b000);

   // R1
   quiet_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid |-> tx_dat == 4'b0000);

   // R2
   tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_valid && fifo_count == '0) |=> !tx_valid);

   // R5
   byte_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && rd_size_lat == 2'd0) |-> rd_data[31:8] == 24'h0);

   // R10
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_done && rd_err));

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_done);
endmodule

bind qed_endian_datapath qed_endian_datapath_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .cfg_mmap(cfg_mmap), .cfg_lanes(cfg_lanes),
   .wr_valid(wr_valid), .wr_size(wr_size), .wr_off(wr_off), .wr_err(wr_err),
   .tx_valid(tx_valid), .tx_dat(tx_dat), .rd_done(rd_done), .rd_err(rd_err),
   .rd_data(rd_data), .rd_size_lat(rd_size_lat), .fifo_count(fifo_count)
);

// File: tb/qed_endian_datapath_tb_top.sv
`timescale 1ns/1ps
module qed_endian_datapath_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_mmap = 1'b0, cfg_dyn = 1'b0;
   logic [1:0]  cfg_static = 2'd0, cfg_lanes = 2'd2;
   logic        wr_valid = 1'b0;
   logic [1:0]  wr_size = 2'd0, wr_off = 2'd0;
   logic [31:0] wr_data = '0;
   logic        wr_ready, wr_err, tx_valid;
   logic [3:0]  tx_dat;
   logic        rd_start = 1'b0;
   logic [1:0]  rd_size = 2'd0, rd_off = 2'd0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rd_busy, rd_done, rd_err;
   logic [31:0] rd_data;

   int checks = 0, failures = 0;
   int nbits = 0, nvalid = 0, lane_bad = 0;
   logic rx_bits [0:1023];
   bit done_flag = 0;

   always #5 clk = ~clk;

   qed_endian_datapath dut_i (.*);

   always @(negedge clk) begin
      if (tx_valid) begin
         nvalid++;
         case (cfg_lanes)
            2'd0: begin
               rx_bits[nbits] = tx_dat[0]; nbits++;
               if (tx_dat[3:1] != 3'b000) lane_bad++;
            end
            2'd1: begin
               rx_bits[nbits] = tx_dat[1]; rx_bits[nbits+1] = tx_dat[0]; nbits += 2;
               if (tx_dat[3:2] != 2'b00) lane_bad++;
            end
            default: begin
               for (int i = 0; i < 4; i++) rx_bits[nbits+i] = tx_dat[3-i];
               nbits += 4;
            end
         endcase
      end
   end

   function automatic logic [7:0] wire_byte(input int k);
      logic [7:0] b;
      for (int i = 0; i < 8; i++) b[7-i] = rx_bits[8*k+i];
      return b;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic clear_capture();
      nbits = 0; nvalid = 0; lane_bad = 0;
   endtask

   task automatic wr(input logic [1:0] sz, input logic [1:0] off, input logic [31:0] d);
      wr_valid = 1'b1; wr_size = sz; wr_off = off; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic drain();
      repeat (3) @(negedge clk);
      while (tx_valid) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] sz, input logic [1:0] off,
                     input logic [31:0] stream, input int n,
                     input logic [31:0] exp, input string req);
      rd_start = 1'b1; rd_size = sz; rd_off = off;
      @(negedge clk);
      rd_start = 1'b0;
      for (int k = 0; k < n; k++) begin
         rx_valid = 1'b1; rx_byte = stream[8*k +: 8];
         @(negedge clk);
      end
      rx_valid = 1'b0;
      check({req, " done"}, {31'h0, rd_done}, 32'h1);
      check({req, " data"}, rd_data, exp);
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R12 wr_ready", {31'h0, wr_ready}, 32'h1);
      check("R12 idle outputs", {27'h0, tx_valid, rd_done, rd_busy, wr_err, rd_err}, 32'h0);
   endtask

   task automatic t_write_default();
      cfg_mmap = 1'b0; cfg_dyn = 1'b0; cfg_lanes = 2'd2;
      clear_capture();
      wr(2'd2, 2'd0, 32'h04030201);
      drain();
      check("R3 word wire order", {wire_byte(0), wire_byte(1), wire_byte(2), wire_byte(3)}, 32'h04030201);
      check("R2 quad word cycles", nvalid, 32'd8);
      clear_capture();
      wr(2'd1, 2'd0, 32'h00000201);
      drain();
      check("R3 half wire order", {16'h0, wire_byte(0), wire_byte(1)}, 32'h00000201);
      clear_capture();
      cfg_mmap = 1'b1; cfg_static = 2'd2;
      wr(2'd2, 2'd0, 32'h04030201);
      drain();
      check("R3 static mmap word", {wire_byte(0), wire_byte(1), wire_byte(2), wire_byte(3)}, 32'h04030201);
      cfg_mmap = 1'b0; cfg_static = 2'd0;
   endtask

   task automatic t_write_lanes();
      clear_capture();
      cfg_lanes = 2'd1;
      wr(2'd1, 2'd0, 32'h0000A5C3);
      drain();
      check("R1 dual half bytes", {16'h0, wire_byte(0), wire_byte(1)}, 32'h0000A5C3);
      check("R2 dual half cycles", nvalid, 32'd8);
      check("R1 dual upper lanes", lane_bad, 32'd0);
      clear_capture();
      cfg_lanes = 2'd0;
      wr(2'd0, 2'd0, 32'h00000081);
      drain();
      check("R1 single byte", {24'h0, wire_byte(0)}, 32'h81);
      check("R2 single byte cycles", nvalid, 32'd8);
      check("R1 single upper lanes", lane_bad, 32'd0);
      cfg_lanes = 2'd2;
   endtask

   task automatic t_write_dynamic();
      cfg_mmap = 1'b1; cfg_dyn = 1'b1; cfg_static = 2'd0; cfg_lanes = 2'd2;
      clear_capture();
      wr(2'd2, 2'd0, 32'h04030201);
      wr(2'd1, 2'd2, 32'h00000201);
      drain();
      check("R4 dyn word", {wire_byte(0), wire_byte(1), wire_byte(2), wire_byte(3)}, 32'h01020304);
      check("R4 dyn half", {16'h0, wire_byte(4), wire_byte(5)}, 32'h00000102);
      check("R2 back-to-back cycles", nvalid, 32'd12);
      cfg_dyn = 1'b0; cfg_mmap = 1'b0;
   endtask

   task automatic t_read_static();
      cfg_mmap = 1'b1; cfg_dyn = 1'b0; cfg_lanes = 2'd2;
      cfg_static = 2'd0;
      rd(2'd1, 2'd0, 32'h00000201, 2, 32'h00000102, "R6 mode0 half");
      rd(2'd2, 2'd0, 32'h04030201, 4, 32'h01020304, "R6 mode0 word");
      rd(2'd1, 2'd2, 32'h00000403, 2, 32'h00000304, "R6 mode0 half off2");
      cfg_static = 2'd3;
      rd(2'd2, 2'd0, 32'h04030201, 4, 32'h01020304, "R6 mode3 word");
      cfg_static = 2'd1;
      rd(2'd1, 2'd0, 32'h00000201, 2, 32'h00000201, "R7 mode1 half");
      rd(2'd2, 2'd0, 32'h04030201, 4, 32'h02010403, "R7 mode1 word");
      rd(2'd0, 2'd3, 32'h00000004, 1, 32'h00000004, "R5 mode1 byte");
      cfg_static = 2'd2;
      rd(2'd1, 2'd0, 32'h00000201, 2, 32'h00000201, "R8 mode2 half");
      rd(2'd2, 2'd0, 32'h04030201, 4, 32'h04030201, "R8 mode2 word");
      rd(2'd0, 2'd1, 32'h00000002, 1, 32'h00000002, "R5 mode2 byte");
   endtask

   task automatic t_read_dynamic();
      cfg_mmap = 1'b1; cfg_dyn = 1'b1; cfg_static = 2'd1;
      rd(2'd2, 2'd0, 32'h04030201, 4, 32'h04030201, "R9 dyn over static");
      cfg_mmap = 1'b0; cfg_static = 2'd2;
      rd(2'd2, 2'd0, 32'h04030201, 4, 32'h01020304, "R9 dyn ignored unmapped");
      cfg_dyn = 1'b0; cfg_static = 2'd0;
   endtask

   task automatic t_errors();
      cfg_mmap = 1'b0; cfg_lanes = 2'd2;
      clear_capture();
      wr(2'd1, 2'd1, 32'h00001234);
      check("R10 misaligned write err", {31'h0, wr_err}, 32'h1);
      drain();
      check("R10 misaligned write silent", nvalid, 32'd0);
      rd_start = 1'b1; rd_size = 2'd2; rd_off = 2'd2;
      @(negedge clk);
      rd_start = 1'b0;
      check("R10 misaligned read err", {31'h0, rd_err}, 32'h1);
      repeat (3) begin
         rx_valid = 1'b1; rx_byte = 8'h55;
         @(negedge clk);
         check("R10 misaligned read no done", {31'h0, rd_done | rd_busy}, 32'h0);
      end
      rx_valid = 1'b0;
      cfg_mmap = 1'b1; cfg_lanes = 2'd0;
      clear_capture();
      wr(2'd2, 2'd0, 32'hCAFEF00D);
      check("R11 mmap single write err", {31'h0, wr_err}, 32'h1);
      drain();
      check("R11 mmap single silent", nvalid, 32'd0);
      rd_start = 1'b1; rd_size = 2'd0; rd_off = 2'd0;
      @(negedge clk);
      rd_start = 1'b0;
      check("R11 mmap single read err", {31'h0, rd_err}, 32'h1);
      cfg_mmap = 1'b0; cfg_lanes = 2'd2;
      @(negedge clk);
   endtask

   task automatic t_full();
      cfg_mmap = 1'b0; cfg_lanes = 2'd0;
      clear_capture();
      for (int i = 0; i < 5; i++) wr(2'd2, 2'd0, 32'h10203040 + i);
      check("R13 ready low when full", {31'h0, wr_ready}, 32'h0);
      wr(2'd2, 2'd0, 32'hDEADBEEF);
      drain();
      check("R13 dropped write bits", nbits, 32'd160);
      check("R2 five entries no gap", nvalid, 32'd160);
      check("R13 last kept entry", {wire_byte(16), wire_byte(17), wire_byte(18), wire_byte(19)}, 32'h10203044);
      check("R13 ready restored", {31'h0, wr_ready}, 32'h1);
      cfg_lanes = 2'd2;
   endtask

   task automatic t_overlap();
      cfg_mmap = 1'b1; cfg_dyn = 1'b1; cfg_lanes = 2'd2;
      clear_capture();
      wr(2'd2, 2'd0, 32'hDDCCBBAA);
      rd(2'd2, 2'd0, 32'h44332211, 4, 32'h44332211, "R9 read during write");
      drain();
      check("R4 write during read", {wire_byte(0), wire_byte(1), wire_byte(2), wire_byte(3)}, 32'hAABBCCDD);
      cfg_dyn = 1'b0; cfg_mmap = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_default();
      t_write_lanes();
      t_write_dynamic();
      t_read_static();
      t_read_dynamic();
      t_errors();
      t_full();
      t_overlap();
      if (!done_flag) begin
         done_flag = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done_flag) begin
         done_flag = 1;
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule